// File: doc/BRIEF.md
# Filtered Quadrature Position Decoder with Index Reset

This block turns the two phase lines of an incremental rotary or linear encoder into a signed-free, wrapping up/down position count. Each of the three raw lines (phase 0, phase 90 and the once-per-turn index mark) first passes through a programmable glitch filter, so a level reaches the decoder only after it has been held for a chosen number of clocks. The filtered phase pair is decoded as a two-bit Gray code: every single-step move adds or subtracts one from the count, and a move in which both phases flip together is reported as an error.

An optional index path clears the position count. A clear happens only when the filtered index line rises while the filtered phase pair sits in a software-selected state, which pins the zero position to one specific quarter of the encoder cycle. All behaviour is set by one 8-bit control register written through a simple write-enable port and readable at all times. The index path is intended for encoders that drive an index line; when no such line is connected, software leaves index handling switched off.

Top module: `quad_pos_decoder`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `count`, `dir_up`, `count_evt`, `step_err`, `idx_evt` and `cfg_rdata` are all zero, so decoding and index handling are off and the filter length field is zero.
- R2: A clock edge with `cfg_we` high loads the control register from `cfg_wdata`; from the next cycle `cfg_rdata` shows the stored value. Field layout: bit 0 decode enable, bit 1 index enable, bits 3:2 index match state, bits 6:4 filter length. Bit 7 is reserved: it always reads as zero whatever is written.
- R3: With filter length N, a filtered line takes a new level only after the raw line has shown that level on at least N+1 consecutive clock edges; shorter excursions are dropped. With N = 0 a level change seen at one edge is passed on at that edge, and its effect on `count` is visible one edge later.
- R4: With decode enable set, the filtered pair {phase 0, phase 90} stepping 00→01→11→10→00 increments `count` by one per step, the reverse order decrements it, `count_evt` is high for one clock per step and `dir_up` holds 1 after an up step and 0 after a down step.
- R5: A move in which both filtered phases change at the same edge raises `step_err` for one clock, leaves `count` and `dir_up` unchanged and produces no `count_evt`.
- R6: While decode enable is clear, `count` and `dir_up` do not change through phase activity, and `count_evt` and `step_err` stay low.
- R7: With index enable set, a rising edge of the filtered index line while the filtered phase pair equals the index match state clears `count` to zero and raises `idx_evt` for exactly one clock.
- R8: With index enable clear, or with the phase pair differing from the match state at the rising edge, the index line has no effect on `count` and `idx_evt` stays low.
- R9: `count` is 16 bits wide and wraps modulo 65536 in both directions.
- R10: When an accepted index and a counted step fall in the same cycle, `count` becomes zero, while `count_evt` and `dir_up` still report the step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control register write data |
| cfg_rdata | output | 8 | Control register read data, bit 7 always zero |
| ph0_in | input | 1 | Raw phase 0 line from the encoder |
| ph90_in | input | 1 | Raw phase 90 line from the encoder |
| idx_in | input | 1 | Raw index line from the encoder |
| count | output | COUNT_W (16) | Position count |
| dir_up | output | 1 | Direction of the last counted step, 1 = up |
| count_evt | output | 1 | One-clock pulse per counted step |
| step_err | output | 1 | One-clock pulse on a two-phase jump |
| idx_evt | output | 1 | One-clock pulse on an accepted index |

## Verification
The bench builds the decoder with its default 16-bit count and the 3-bit filter field fixed by the register layout. The 16-bit width puts wrap-around within one down step from zero, and the small filter field lets random register writes visit every filter length from one to eight samples, as well as length changes made while a filter is part-way through a count. Random phase walks with injected glitches, two-phase jumps and index pulses then cover the interplay of filtering, decode and index matching in all four match states.

// File: rtl/qpd_pkg.sv
package qpd_pkg;

    localparam int FILT_W    = 3;
    localparam int CFG_W     = 8;
    localparam int NUM_LINES = 3;
    localparam int LINE_PH0  = 0;
    localparam int LINE_PH90 = 1;
    localparam int LINE_IDX  = 2;

    // stored control fields; bit 7 of the register is not stored
    typedef struct packed {
        logic [FILT_W-1:0] filt_len;   // bits 6:4
        logic [1:0]        idx_state;  // bits 3:2
        logic              idx_en;     // bit 1
        logic              dec_en;     // bit 0
    } qpd_cfg_t;

    localparam int CFG_STORED_W = $bits(qpd_cfg_t);

    typedef enum logic [1:0] {
        STEP_NONE = 2'd0,
        STEP_UP   = 2'd1,
        STEP_DOWN = 2'd2,
        STEP_ERR  = 2'd3
    } step_kind_e;

    // position of a {ph0, ph90} Gray state along the up sequence 00,01,11,10
    function automatic logic [1:0] gray_pos(input logic [1:0] s);
        return {s[1], s[1] ^ s[0]};
    endfunction

    function automatic step_kind_e classify_step(input logic [1:0] old_s,
                                                 input logic [1:0] new_s);
        logic [1:0] diff;
        diff = gray_pos(new_s) - gray_pos(old_s);
        case (diff)
            2'd1:    return STEP_UP;
            2'd3:    return STEP_DOWN;
            2'd2:    return STEP_ERR;
            default: return STEP_NONE;
        endcase
    endfunction

endpackage

// File: rtl/qpd_cfg_reg.sv
module qpd_cfg_reg
    import qpd_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [CFG_W-1:0] wdata,
    output qpd_cfg_t         cfg,
    output logic [CFG_W-1:0] rdata
);

    qpd_cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (we) begin
            cfg_q <= qpd_cfg_t'(wdata[CFG_STORED_W-1:0]);
        end
    end

    assign cfg   = cfg_q;
    assign rdata = {{(CFG_W-CFG_STORED_W){1'b0}}, cfg_q};

endmodule

// File: rtl/qpd_glitch_filter.sv
module qpd_glitch_filter #(
    parameter int LEN_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             raw,
    input  logic [LEN_W-1:0] len,
    output logic             filt
);

    logic             level_q;
    logic [LEN_W-1:0] run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            level_q <= 1'b0;
            run_q   <= '0;
        end else if (raw == level_q) begin
            run_q <= '0;
        end else if (run_q >= len) begin
            level_q <= raw;
            run_q   <= '0;
        end else begin
            run_q <= run_q + LEN_W'(1);
        end
    end

    assign filt = level_q;

endmodule

// File: rtl/qpd_edge_detect.sv
module qpd_edge_detect
    import qpd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] ph_now,     // {ph0, ph90}, filtered
    input  logic       idx_now,    // filtered index
    input  logic       idx_en,
    input  logic [1:0] idx_state,
    output step_kind_e step,
    output logic       idx_hit
);

    logic [1:0] ph_prev_q;
    logic       idx_prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_prev_q  <= '0;
            idx_prev_q <= 1'b0;
        end else begin
            ph_prev_q  <= ph_now;
            idx_prev_q <= idx_now;
        end
    end

    assign step    = classify_step(ph_prev_q, ph_now);
    assign idx_hit = idx_en && idx_now && !idx_prev_q && (ph_now == idx_state);

endmodule

// File: rtl/qpd_pos_counter.sv
module qpd_pos_counter
    import qpd_pkg::*;
#(
    parameter int COUNT_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               dec_en,
    input  step_kind_e         step,
    input  logic               idx_hit,
    output logic [COUNT_W-1:0] count,
    output logic               dir_up,
    output logic               count_evt,
    output logic               step_err,
    output logic               idx_evt
);

    always_ff @(posedge clk) begin
        if (rst) begin
            count     <= '0;
            dir_up    <= 1'b0;
            count_evt <= 1'b0;
            step_err  <= 1'b0;
            idx_evt   <= 1'b0;
        end else begin
            count_evt <= 1'b0;
            step_err  <= 1'b0;
            idx_evt   <= 1'b0;
            if (dec_en) begin
                case (step)
                    STEP_UP: begin
                        count     <= count + COUNT_W'(1);
                        count_evt <= 1'b1;
                        dir_up    <= 1'b1;
                    end
                    STEP_DOWN: begin
                        count     <= count - COUNT_W'(1);
                        count_evt <= 1'b1;
                        dir_up    <= 1'b0;
                    end
                    STEP_ERR: step_err <= 1'b1;
                    default: ;
                endcase
            end
            if (idx_hit) begin
                count   <= '0;
                idx_evt <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/quad_pos_decoder.sv
module quad_pos_decoder
    import qpd_pkg::*;
#(
    parameter int COUNT_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_we,
    input  logic [7:0]         cfg_wdata,
    output logic [7:0]         cfg_rdata,
    input  logic               ph0_in,
    input  logic               ph90_in,
    input  logic               idx_in,
    output logic [COUNT_W-1:0] count,
    output logic               dir_up,
    output logic               count_evt,
    output logic               step_err,
    output logic               idx_evt
);

    qpd_cfg_t             cfg;
    logic [NUM_LINES-1:0] raw_lines;
    logic [NUM_LINES-1:0] filt_lines;
    step_kind_e           step;
    logic                 idx_hit;

    qpd_cfg_reg u_cfg (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .cfg   (cfg),
        .rdata (cfg_rdata)
    );

    assign raw_lines[LINE_PH0]  = ph0_in;
    assign raw_lines[LINE_PH90] = ph90_in;
    assign raw_lines[LINE_IDX]  = idx_in;

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_filt
        qpd_glitch_filter #(.LEN_W(FILT_W)) u_filt (
            .clk  (clk),
            .rst  (rst),
            .raw  (raw_lines[i]),
            .len  (cfg.filt_len),
            .filt (filt_lines[i])
        );
    end

    qpd_edge_detect u_edge (
        .clk       (clk),
        .rst       (rst),
        .ph_now    ({filt_lines[LINE_PH0], filt_lines[LINE_PH90]}),
        .idx_now   (filt_lines[LINE_IDX]),
        .idx_en    (cfg.idx_en),
        .idx_state (cfg.idx_state),
        .step      (step),
        .idx_hit   (idx_hit)
    );

    qpd_pos_counter #(.COUNT_W(COUNT_W)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .dec_en    (cfg.dec_en),
        .step      (step),
        .idx_hit   (idx_hit),
        .count     (count),
        .dir_up    (dir_up),
        .count_evt (count_evt),
        .step_err  (step_err),
        .idx_evt   (idx_evt)
    );

endmodule

// File: rtl/qpd_checker.sv
module qpd_checker #(
    parameter int COUNT_W = 16
) (
    input logic               clk,
    input logic               rst,
    input logic [7:0]         cfg_rdata,
    input logic [COUNT_W-1:0] count,
    input logic               dir_up,
    input logic               count_evt,
    input logic               step_err,
    input logic               idx_evt
);

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
        !cfg_rdata[7]); // R2

    AST_STEP_SIZE: assert property (@(posedge clk) disable iff (rst)
        (count_evt && !idx_evt) |->
            (count == (dir_up ? $past(count) + COUNT_W'(1) : $past(count) - COUNT_W'(1)))); // R4

    AST_ERR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (step_err && !idx_evt) |-> ($stable(count) && $stable(dir_up) && !count_evt)); // R5

    AST_DEC_OFF: assert property (@(posedge clk) disable iff (rst)
        (!$past(cfg_rdata[0]) && !idx_evt) |-> ($stable(count) && !count_evt && !step_err)); // R6

    AST_IDX_CLEAR: assert property (@(posedge clk) disable iff (rst)
        idx_evt |-> (count == '0)); // R7

    AST_IDX_SINGLE: assert property (@(posedge clk) disable iff (rst)
        idx_evt |=> !idx_evt); // R7

    AST_IDX_OFF: assert property (@(posedge clk) disable iff (rst)
        !$past(cfg_rdata[1]) |-> !idx_evt); // R8

endmodule

bind quad_pos_decoder qpd_checker #(.COUNT_W(COUNT_W)) u_qpd_chk (
    .clk       (clk),
    .rst       (rst),
    .cfg_rdata (cfg_rdata),
    .count     (count),
    .dir_up    (dir_up),
    .count_evt (count_evt),
    .step_err  (step_err),
    .idx_evt   (idx_evt)
);

// File: tb/tb_quad_pos_decoder.sv
module tb_quad_pos_decoder;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_we;
    logic [7:0]  cfg_wdata;
    logic [7:0]  cfg_rdata;
    logic        ph0_in, ph90_in, idx_in;
    logic [15:0] count;
    logic        dir_up, count_evt, step_err, idx_evt;

    always #2 clk = ~clk;

    quad_pos_decoder dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .ph0_in(ph0_in), .ph90_in(ph90_in), .idx_in(idx_in),
        .count(count), .dir_up(dir_up), .count_evt(count_evt),
        .step_err(step_err), .idx_evt(idx_evt)
    );

    int    n_vec = 0;
    int    n_bad = 0;
    bit    done  = 0;
    string cur_req = "R1";

    // stimulus state: phase pair {ph0, ph90} and index level
    logic [1:0] cur_ph = 2'b00;
    logic       cur_idx = 1'b0;

    // reference model state
    logic [6:0]  m_cfg;
    logic [2:0]  m_lvl;       // [0] ph0, [1] ph90, [2] idx
    int          m_run [3];
    logic [1:0]  m_prev;
    logic        m_iprev;
    logic [15:0] m_count;
    logic        m_dir, m_evt, m_err, m_ievt;

    function automatic logic [1:0] next_up(input logic [1:0] s);
        case (s)
            2'b00: return 2'b01;
            2'b01: return 2'b11;
            2'b11: return 2'b10;
            default: return 2'b00;
        endcase
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_cfg = '0; m_lvl = '0; m_prev = '0; m_iprev = 1'b0;
        m_count = '0; m_dir = 1'b0; m_evt = 1'b0; m_err = 1'b0; m_ievt = 1'b0;
        for (int i = 0; i < 3; i++) m_run[i] = 0;
    endtask

    task automatic model_edge(input logic we, input logic [7:0] wd, input logic [2:0] raw);
        logic [1:0] fph;
        int         len;
        fph = {m_lvl[0], m_lvl[1]};
        len = int'(m_cfg[6:4]);
        m_evt = 1'b0; m_err = 1'b0; m_ievt = 1'b0;
        if (m_cfg[0]) begin
            if (fph == next_up(m_prev)) begin
                m_count = m_count + 16'd1; m_evt = 1'b1; m_dir = 1'b1;
            end else if (m_prev == next_up(fph)) begin
                m_count = m_count - 16'd1; m_evt = 1'b1; m_dir = 1'b0;
            end else if (fph == ~m_prev) begin
                m_err = 1'b1;
            end
        end
        if (m_cfg[1] && m_lvl[2] && !m_iprev && fph == m_cfg[3:2]) begin
            m_count = '0; m_ievt = 1'b1;
        end
        m_prev  = fph;
        m_iprev = m_lvl[2];
        for (int i = 0; i < 3; i++) begin
            if (raw[i] == m_lvl[i]) m_run[i] = 0;
            else if (m_run[i] >= len) begin m_lvl[i] = raw[i]; m_run[i] = 0; end
            else m_run[i] = m_run[i] + 1;
        end
        if (we) m_cfg = wd[6:0];
    endtask

    task automatic compare_all();
        chk(cur_req, "count",     int'(count),     int'(m_count));
        chk(cur_req, "dir_up",    int'(dir_up),    int'(m_dir));
        chk(cur_req, "count_evt", int'(count_evt), int'(m_evt));
        chk(cur_req, "step_err",  int'(step_err),  int'(m_err));
        chk(cur_req, "idx_evt",   int'(idx_evt),   int'(m_ievt));
        chk("R2",    "cfg_rdata", int'(cfg_rdata), int'({1'b0, m_cfg}));
    endtask

    task automatic cyc(input logic we, input logic [7:0] wd);
        logic [2:0] raw;
        @(negedge clk);
        raw = {cur_idx, cur_ph[0], cur_ph[1]};
        cfg_we = we; cfg_wdata = wd;
        ph0_in = raw[0]; ph90_in = raw[1]; idx_in = raw[2];
        @(posedge clk);
        model_edge(we, wd, raw);
        #1;
        compare_all();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(1'b0, 8'h00);
    endtask

    task automatic write_cfg(input logic [7:0] v);
        cyc(1'b1, v);
    endtask

    task automatic move(input bit up, input int hold);
        cur_ph = up ? next_up(cur_ph) : {cur_ph[0] ^ cur_ph[1] ^ 1'b1, cur_ph[1]} ;
        idle(hold);
    endtask

    // down step: the state whose up successor is the current one
    task automatic move_down(input int hold);
        logic [1:0] t;
        t = 2'b00;
        for (int k = 0; k < 4; k++) if (next_up(2'(k)) == cur_ph) t = 2'(k);
        cur_ph = t;
        idle(hold);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL R1 watchdog expired actual=running expected=finished");
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] snap;
        void'($urandom(32'h5EED_0042));
        rst = 1'b1; cfg_we = 1'b0; cfg_wdata = '0;
        ph0_in = 1'b0; ph90_in = 1'b0; idx_in = 1'b0;
        model_reset();
        repeat (3) @(posedge clk);
        #1;
        chk("R1", "count in reset", int'(count), 0);
        chk("R1", "rdata in reset", int'(cfg_rdata), 0);
        chk("R1", "events in reset", int'({dir_up, count_evt, step_err, idx_evt}), 0);
        @(negedge clk); rst = 1'b0;
        @(posedge clk); #1;
        chk("R1", "count after reset", int'(count), 0);
        chk("R1", "rdata after reset", int'(cfg_rdata), 0);

        // R2: reserved bit reads zero
        cur_req = "R2";
        write_cfg(8'hFE);
        chk("R2", "reserved bit masked", int'(cfg_rdata), 8'h7E);
        write_cfg(8'h00);

        // R6: decode off, phases walk, nothing counts
        cur_req = "R6";
        for (int i = 0; i < 6; i++) move(1'b1, 3);
        cur_ph = ~cur_ph; idle(3);
        chk("R6", "count frozen while disabled", int'(count), 0);

        // R4: up then down with filter length 0
        cur_req = "R4";
        write_cfg(8'h01);
        idle(2);
        for (int i = 0; i < 4; i++) move(1'b1, 3);
        chk("R4", "four up steps", int'(count), 4);
        chk("R4", "direction up", int'(dir_up), 1);
        for (int i = 0; i < 4; i++) move_down(3);
        chk("R4", "back to zero", int'(count), 0);
        chk("R4", "direction down", int'(dir_up), 0);

        // R9: wrap below zero and back
        cur_req = "R9";
        move_down(3);
        chk("R9", "wrap to all ones", int'(count), 16'hFFFF);
        move(1'b1, 3);
        chk("R9", "wrap back to zero", int'(count), 0);

        // R5: both phases flip
        cur_req = "R5";
        move(1'b1, 3);
        snap = count;
        cur_ph = ~cur_ph; idle(4);
        chk("R5", "count kept on jump", int'(count), int'(snap));

        // R3: filter length 3 needs four samples
        cur_req = "R3";
        write_cfg(8'h31);
        idle(6);
        snap = count;
        begin
            logic [1:0] keep;
            keep = cur_ph;
            cur_ph = next_up(keep); idle(3);
            cur_ph = keep; idle(6);
        end
        chk("R3", "three-sample glitch dropped", int'(count), int'(snap));
        cur_ph = next_up(cur_ph); idle(4);
        chk("R3", "not yet counted after four edges", int'(count), int'(snap));
        idle(1);
        chk("R3", "counted after filter plus decode", int'(count), int'(snap + 16'd1));
        write_cfg(8'h01);
        idle(2);

        // R8: index disabled, then index enabled with wrong state
        cur_req = "R8";
        snap = count;
        cur_idx = 1'b1; idle(3); cur_idx = 1'b0; idle(3);
        chk("R8", "index ignored when disabled", int'(count), int'(snap));
        write_cfg({1'b0, 3'd0, ~cur_ph[1], cur_ph[0], 2'b11});
        cur_idx = 1'b1; idle(3); cur_idx = 1'b0; idle(3);
        chk("R8", "index ignored on state mismatch", int'(count), int'(snap));

        // R7: index accepted in matching state
        cur_req = "R7";
        write_cfg({1'b0, 3'd0, cur_ph, 2'b11});
        move(1'b1, 2); move_down(2);
        cur_idx = 1'b1; idle(3); cur_idx = 1'b0; idle(2);
        chk("R7", "index clears count", int'(count), 0);
        move(1'b1, 3); move(1'b1, 3);
        chk("R7", "counting resumes", int'(count), 2);

        // R10: step and index in the same cycle
        cur_req = "R10";
        write_cfg({1'b0, 3'd0, next_up(cur_ph), 2'b11});
        idle(2);
        cur_ph = next_up(cur_ph); cur_idx = 1'b1;
        cyc(1'b0, 8'h00);
        cyc(1'b0, 8'h00);
        chk("R10", "index wins over step", int'(count), 0);
        chk("R10", "step still reported", int'({count_evt, idx_evt, dir_up}), 3'b111);
        cur_idx = 1'b0; idle(3);

        // random mix: filter lengths, jumps, glitches, index pulses
        cur_req = "R4";
        for (int n = 0; n < 20000; n++) begin
            int r;
            r = int'($urandom_range(0, 999));
            if (r < 5) begin
                cyc(1'b1, 8'($urandom));
                continue;
            end
            r = int'($urandom_range(0, 99));
            if (r < 20) cur_ph = next_up(cur_ph);
            else if (r < 38) begin
                logic [1:0] t;
                t = cur_ph;
                for (int k = 0; k < 4; k++) if (next_up(2'(k)) == cur_ph) t = 2'(k);
                cur_ph = t;
            end
            else if (r < 40) cur_ph = ~cur_ph;
            if ($urandom_range(0, 19) == 0) cur_idx = ~cur_idx;
            cyc(1'b0, 8'h00);
        end

        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule